// File: doc/BRIEF.md
# Root Port Configuration and Memory Request Router

This block makes the routing decision for every request that reaches a downstream-facing root port from the host side. The port looks to software like a bridge between two buses. It keeps its secondary bus number, its subordinate bus number and two memory windows in a small register set. Software reaches that register set with type 0 configuration requests. Each incoming request has one of four outcomes: it is sent on unchanged, it is rewritten from type 1 to type 0 and sent on, it is answered by the port itself, or it is refused with an Unsupported Request completion.

For configuration traffic the port also builds the upstream completion. A forwarded configuration request holds the port until the downstream completion comes back. Reads that cannot succeed return a dword of all ones. The causes are a missing device behind the link, a downstream Unsupported Request, a link that is down, or a bus number outside the port's range. Failed writes are discarded and still get a completion without data. Memory requests that hit a window are passed on as posted traffic and produce no completion here.

Top module: `rp_cfg_router`

## Requirements
- R1: A type 1 configuration request (req_kind = 1) whose bus number B satisfies secondary < B <= subordinate is issued downstream one cycle after acceptance, with dn_kind = 1 and bus, device, function, register and write data unchanged.
- R2: A type 1 request whose bus number equals the secondary bus and whose device number is 0 is issued downstream as a type 0 request (dn_kind = 0), one cycle after acceptance. The equality test takes precedence over the range test.
- R3: A type 0 request (req_kind = 0) is always answered by the port one cycle later, whatever its bus number and link state. The register index selects the register. Index 0 holds the secondary bus in bits 7:0 and the subordinate bus in bits 15:8. Index 1 holds the non-prefetchable window and index 2 the prefetchable window, each with the base in bits 11:0 and the limit in bits 27:16, counted in 1 MiB units. Index 3 reads the port ID in bits 15:0. All other indices read 0 and ignore writes. Reset values are bus numbers 0, window bases 0xFFF and window limits 0.
- R4: A memory request (req_kind = 2) whose address bits 31:20 lie within base..limit of either window is issued downstream with dn_kind = 2 while the link is up. Every other memory request gets an Unsupported Request completion. A window whose limit is below its base matches nothing.
- R5: Every upstream completion carries cpl_id equal to rp_id, and every downstream request carries dn_rid equal to rp_id.
- R6: A type 1 request for the secondary bus with a device number other than 0 is not sent downstream. A read of this kind completes with cpl_ur = 1 and data 0xFFFFFFFF.
- R7: When a downstream completion reports Unsupported Request for a forwarded read, the upstream completion has cpl_ur = 1 and data 0xFFFFFFFF. A successful downstream completion passes its data through with cpl_ur = 0.
- R8: While link_up is low, no configuration or memory request is sent downstream. Such requests complete with cpl_ur = 1, and reads return all ones.
- R9: A type 1 request with a bus number below the secondary bus or above the subordinate bus gets cpl_ur = 1, with all ones for a read. A request with the reserved kind 3 is treated the same way.
- R10: Every write completion has cpl_has_data = 0 and cpl_data = 0, and every read completion has cpl_has_data = 1. A failed write reaches neither the registers nor the downstream side.
- R11: Only one configuration request may be outstanding downstream. req_ready is low from the cycle the request is issued until the cycle the upstream completion appears, which is one cycle after dn_cpl_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rp_id | input | 16 | Port's own bus/device/function number |
| link_up | input | 1 | Downstream link is up |
| req_valid | input | 1 | Upstream request present |
| req_ready | output | 1 | Port can accept a request |
| req_kind | input | 2 | 0 cfg type 0, 1 cfg type 1, 2 memory, 3 reserved |
| req_write | input | 1 | Request is a write |
| req_bus | input | 8 | Target bus number |
| req_dev | input | 5 | Target device number |
| req_fn | input | 3 | Target function number |
| req_reg | input | 6 | Configuration dword index |
| req_addr | input | 32 | Memory address |
| req_wdata | input | 32 | Write data |
| dn_valid | output | 1 | Downstream request issued (one cycle) |
| dn_kind | output | 2 | Kind of downstream request |
| dn_write | output | 1 | Downstream write |
| dn_bus | output | 8 | Downstream bus number |
| dn_dev | output | 5 | Downstream device number |
| dn_fn | output | 3 | Downstream function number |
| dn_reg | output | 6 | Downstream dword index |
| dn_addr | output | 32 | Downstream memory address |
| dn_wdata | output | 32 | Downstream write data |
| dn_rid | output | 16 | Requester ID on downstream requests |
| dn_cpl_valid | input | 1 | Downstream configuration completion |
| dn_cpl_ur | input | 1 | Downstream completion is Unsupported Request |
| dn_cpl_data | input | 32 | Downstream completion data |
| cpl_valid | output | 1 | Upstream completion (one cycle) |
| cpl_ur | output | 1 | Completion status is Unsupported Request |
| cpl_has_data | output | 1 | Completion carries data |
| cpl_data | output | 32 | Completion data |
| cpl_id | output | 16 | Completer ID |

## Verification
The hardest case to reach is a forwarded read whose downstream completion reports Unsupported Request. Only a request that passes every local check can get there, and the port must then be held in its waiting state. To reach it, the bench first programs the bus numbers through type 0 writes. It then sweeps the bus numbers around and beyond the secondary/subordinate range, and answers each request that is actually issued with a completion whose status the bench picks per bus. The same sweep is repeated with the link down, and the window sweep is run with one window disabled by a limit below its base, then enabled.

// File: rtl/rp_pkg.sv
package rp_pkg;
  typedef enum logic [1:0] {
    K_CFG0 = 2'd0,
    K_CFG1 = 2'd1,
    K_MEM  = 2'd2,
    K_RSVD = 2'd3
  } kind_e;

  typedef enum logic [2:0] {
    A_LOCAL,
    A_FWD,
    A_CONV,
    A_MEMFWD,
    A_FAIL
  } act_e;

  localparam int unsigned IDX_BUS  = 0;
  localparam int unsigned IDX_NPW  = 1;
  localparam int unsigned IDX_PFW  = 2;
  localparam int unsigned IDX_ID   = 3;
  localparam int unsigned LIM_LSB  = 16;
endpackage

// File: rtl/rp_cfg_regs.sv
module rp_cfg_regs
  import rp_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned GRAN_SH = 20,
  parameter int unsigned IDX_W   = 6,
  localparam int unsigned WIN_W  = ADDR_W - GRAN_SH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] idx,
  input  logic [31:0]      wr_data,
  input  logic [15:0]      rp_id,
  output logic [7:0]       sec_bus,
  output logic [7:0]       sub_bus,
  output logic [WIN_W-1:0] np_base,
  output logic [WIN_W-1:0] np_lim,
  output logic [WIN_W-1:0] pf_base,
  output logic [WIN_W-1:0] pf_lim,
  output logic [31:0]      rd_data
);
  logic [7:0]       sec_n, sub_n;
  logic [WIN_W-1:0] npb_n, npl_n, pfb_n, pfl_n;

  always_comb begin
    sec_n = sec_bus;
    sub_n = sub_bus;
    npb_n = np_base;
    npl_n = np_lim;
    pfb_n = pf_base;
    pfl_n = pf_lim;
    if (wr_en) begin
      if (idx == IDX_W'(IDX_BUS)) begin
        sec_n = wr_data[7:0];
        sub_n = wr_data[15:8];
      end else if (idx == IDX_W'(IDX_NPW)) begin
        npb_n = wr_data[WIN_W-1:0];
        npl_n = wr_data[LIM_LSB +: WIN_W];
      end else if (idx == IDX_W'(IDX_PFW)) begin
        pfb_n = wr_data[WIN_W-1:0];
        pfl_n = wr_data[LIM_LSB +: WIN_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_bus <= '0;
      sub_bus <= '0;
      np_base <= '1;
      np_lim  <= '0;
      pf_base <= '1;
      pf_lim  <= '0;
    end else if (wr_en) begin
      sec_bus <= sec_n;
      sub_bus <= sub_n;
      np_base <= npb_n;
      np_lim  <= npl_n;
      pf_base <= pfb_n;
      pf_lim  <= pfl_n;
    end
  end

  always_comb begin
    rd_data = '0;
    if (idx == IDX_W'(IDX_BUS))      rd_data = {16'h0, sub_bus, sec_bus};
    else if (idx == IDX_W'(IDX_NPW)) rd_data = {16'(np_lim), 16'(np_base)};
    else if (idx == IDX_W'(IDX_PFW)) rd_data = {16'(pf_lim), 16'(pf_base)};
    else if (idx == IDX_W'(IDX_ID))  rd_data = {16'h0, rp_id};
  end

  AST_WIN_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en) |-> $stable(np_base) && $stable(pf_lim)) else $error("unwritten window changed"); // R3
endmodule

// File: rtl/rp_route_dec.sv
module rp_route_dec
  import rp_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned GRAN_SH = 20,
  localparam int unsigned WIN_W  = ADDR_W - GRAN_SH
) (
  input  kind_e             kind,
  input  logic              link_up,
  input  logic [7:0]        bus,
  input  logic [4:0]        dev,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        sec_bus,
  input  logic [7:0]        sub_bus,
  input  logic [WIN_W-1:0]  np_base,
  input  logic [WIN_W-1:0]  np_lim,
  input  logic [WIN_W-1:0]  pf_base,
  input  logic [WIN_W-1:0]  pf_lim,
  output logic              mem_hit,
  output act_e              act
);
  localparam int unsigned NWIN = 2;
  logic [WIN_W-1:0] page;
  logic [WIN_W-1:0] wb [NWIN];
  logic [WIN_W-1:0] wl [NWIN];
  logic [NWIN-1:0]  hit;

  assign page  = addr[ADDR_W-1:GRAN_SH];
  assign wb[0] = np_base;
  assign wl[0] = np_lim;
  assign wb[1] = pf_base;
  assign wl[1] = pf_lim;

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    assign hit[w] = (wb[w] <= wl[w]) && (page >= wb[w]) && (page <= wl[w]);
  end
  assign mem_hit = |hit;

  always_comb begin
    act = A_FAIL;
    unique case (kind)
      K_CFG0: act = A_LOCAL;
      K_CFG1: begin
        if (bus == sec_bus) begin
          if (link_up && dev == 5'd0) act = A_CONV;
        end else if (bus > sec_bus && bus <= sub_bus) begin
          if (link_up) act = A_FWD;
        end
      end
      K_MEM:  if (link_up && mem_hit) act = A_MEMFWD;
      default: act = A_FAIL;
    endcase
  end
endmodule

// File: rtl/rp_xact_ctl.sv
module rp_xact_ctl
  import rp_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_fire,
  input  act_e              act,
  input  logic              req_write,
  input  logic [7:0]        req_bus,
  input  logic [4:0]        req_dev,
  input  logic [2:0]        req_fn,
  input  logic [IDX_W-1:0]  req_reg,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  input  logic [31:0]       loc_rdata,
  input  logic              dn_cpl_valid,
  input  logic              dn_cpl_ur,
  input  logic [31:0]       dn_cpl_data,
  output logic              req_ready,
  output logic              dn_valid,
  output logic [1:0]        dn_kind,
  output logic              dn_write,
  output logic [7:0]        dn_bus,
  output logic [4:0]        dn_dev,
  output logic [2:0]        dn_fn,
  output logic [IDX_W-1:0]  dn_reg,
  output logic [ADDR_W-1:0] dn_addr,
  output logic [31:0]       dn_wdata,
  output logic              cpl_valid,
  output logic              cpl_ur,
  output logic              cpl_has_data,
  output logic [31:0]       cpl_data
);
  typedef enum logic {S_IDLE, S_WAIT} st_e;
  st_e         st_q, st_n;
  logic        dnv_n, dn_ld, cv_n, ur_n, hd_n, pw_q, pw_n;
  logic [1:0]  kind_n;
  logic [31:0] cd_n;

  assign req_ready = (st_q == S_IDLE);

  always_comb begin
    st_n   = st_q;
    pw_n   = pw_q;
    dnv_n  = 1'b0;
    dn_ld  = 1'b0;
    kind_n = dn_kind;
    cv_n   = 1'b0;
    ur_n   = cpl_ur;
    hd_n   = cpl_has_data;
    cd_n   = cpl_data;
    if (st_q == S_IDLE) begin
      if (req_fire) begin
        unique case (act)
          A_LOCAL: begin
            cv_n = 1'b1;
            ur_n = 1'b0;
            hd_n = !req_write;
            cd_n = req_write ? 32'h0 : loc_rdata;
          end
          A_FWD, A_CONV: begin
            dnv_n  = 1'b1;
            dn_ld  = 1'b1;
            kind_n = (act == A_CONV) ? 2'(K_CFG0) : 2'(K_CFG1);
            pw_n   = req_write;
            st_n   = S_WAIT;
          end
          A_MEMFWD: begin
            dnv_n  = 1'b1;
            dn_ld  = 1'b1;
            kind_n = 2'(K_MEM);
          end
          default: begin
            cv_n = 1'b1;
            ur_n = 1'b1;
            hd_n = !req_write;
            cd_n = req_write ? 32'h0 : 32'hFFFF_FFFF;
          end
        endcase
      end
    end else if (dn_cpl_valid) begin
      cv_n = 1'b1;
      ur_n = dn_cpl_ur;
      hd_n = !pw_q;
      cd_n = pw_q ? 32'h0 : (dn_cpl_ur ? 32'hFFFF_FFFF : dn_cpl_data);
      st_n = S_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q         <= S_IDLE;
      pw_q         <= 1'b0;
      dn_valid     <= 1'b0;
      cpl_valid    <= 1'b0;
      dn_kind      <= '0;
      dn_write     <= 1'b0;
      dn_bus       <= '0;
      dn_dev       <= '0;
      dn_fn        <= '0;
      dn_reg       <= '0;
      dn_addr      <= '0;
      dn_wdata     <= '0;
      cpl_ur       <= 1'b0;
      cpl_has_data <= 1'b0;
      cpl_data     <= '0;
    end else begin
      st_q      <= st_n;
      pw_q      <= pw_n;
      dn_valid  <= dnv_n;
      cpl_valid <= cv_n;
      if (dn_ld) begin
        dn_kind  <= kind_n;
        dn_write <= req_write;
        dn_bus   <= req_bus;
        dn_dev   <= req_dev;
        dn_fn    <= req_fn;
        dn_reg   <= req_reg;
        dn_addr  <= req_addr;
        dn_wdata <= req_wdata;
      end
      if (cv_n) begin
        cpl_ur       <= ur_n;
        cpl_has_data <= hd_n;
        cpl_data     <= cd_n;
      end
    end
  end

  AST_FAIL_READ_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_valid && cpl_ur && cpl_has_data |-> cpl_data == 32'hFFFF_FFFF) else $error("failed read not all ones"); // R7
  AST_WRITE_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_valid && !cpl_has_data |-> cpl_data == 32'h0) else $error("write completion carries data"); // R10
  AST_HOLD_WHILE_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready && !dn_cpl_valid |=> !cpl_valid && !dn_valid) else $error("activity while waiting"); // R11
endmodule

// File: rtl/rp_cfg_router.sv
module rp_cfg_router
  import rp_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned GRAN_SH = 20,
  parameter int unsigned IDX_W   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       rp_id,
  input  logic              link_up,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_kind,
  input  logic              req_write,
  input  logic [7:0]        req_bus,
  input  logic [4:0]        req_dev,
  input  logic [2:0]        req_fn,
  input  logic [IDX_W-1:0]  req_reg,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              dn_valid,
  output logic [1:0]        dn_kind,
  output logic              dn_write,
  output logic [7:0]        dn_bus,
  output logic [4:0]        dn_dev,
  output logic [2:0]        dn_fn,
  output logic [IDX_W-1:0]  dn_reg,
  output logic [ADDR_W-1:0] dn_addr,
  output logic [31:0]       dn_wdata,
  output logic [15:0]       dn_rid,
  input  logic              dn_cpl_valid,
  input  logic              dn_cpl_ur,
  input  logic [31:0]       dn_cpl_data,
  output logic              cpl_valid,
  output logic              cpl_ur,
  output logic              cpl_has_data,
  output logic [31:0]       cpl_data,
  output logic [15:0]       cpl_id
);
  localparam int unsigned WIN_W = ADDR_W - GRAN_SH;

  logic [7:0]       sec_bus, sub_bus;
  logic [WIN_W-1:0] np_base, np_lim, pf_base, pf_lim;
  logic [31:0]      loc_rdata;
  logic             mem_hit, req_fire, reg_we;
  act_e             act;

  assign req_fire = req_valid && req_ready;
  assign reg_we   = req_fire && (act == A_LOCAL) && req_write;
  assign dn_rid   = rp_id;
  assign cpl_id   = rp_id;

  rp_cfg_regs #(.ADDR_W(ADDR_W), .GRAN_SH(GRAN_SH), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_we), .idx(req_reg), .wr_data(req_wdata),
    .rp_id(rp_id), .sec_bus(sec_bus), .sub_bus(sub_bus), .np_base(np_base),
    .np_lim(np_lim), .pf_base(pf_base), .pf_lim(pf_lim), .rd_data(loc_rdata)
  );

  rp_route_dec #(.ADDR_W(ADDR_W), .GRAN_SH(GRAN_SH)) u_dec (
    .kind(kind_e'(req_kind)), .link_up(link_up), .bus(req_bus), .dev(req_dev),
    .addr(req_addr), .sec_bus(sec_bus), .sub_bus(sub_bus), .np_base(np_base),
    .np_lim(np_lim), .pf_base(pf_base), .pf_lim(pf_lim), .mem_hit(mem_hit), .act(act)
  );

  rp_xact_ctl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .req_fire(req_fire), .act(act), .req_write(req_write),
    .req_bus(req_bus), .req_dev(req_dev), .req_fn(req_fn), .req_reg(req_reg),
    .req_addr(req_addr), .req_wdata(req_wdata), .loc_rdata(loc_rdata),
    .dn_cpl_valid(dn_cpl_valid), .dn_cpl_ur(dn_cpl_ur), .dn_cpl_data(dn_cpl_data),
    .req_ready(req_ready), .dn_valid(dn_valid), .dn_kind(dn_kind), .dn_write(dn_write),
    .dn_bus(dn_bus), .dn_dev(dn_dev), .dn_fn(dn_fn), .dn_reg(dn_reg), .dn_addr(dn_addr),
    .dn_wdata(dn_wdata), .cpl_valid(cpl_valid), .cpl_ur(cpl_ur),
    .cpl_has_data(cpl_has_data), .cpl_data(cpl_data)
  );

  AST_FWD_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid && dn_kind == 2'd1 |-> $past(req_bus) > $past(sec_bus) && $past(req_bus) <= $past(sub_bus))
    else $error("type 1 forwarded outside range"); // R1
  AST_CONV_ON_SEC: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid && dn_kind == 2'd0 |-> $past(req_bus) == $past(sec_bus) && $past(req_dev) == 5'd0)
    else $error("type 0 issued for wrong bus or device"); // R2
  AST_MEM_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid && dn_kind == 2'd2 |-> $past(mem_hit)) else $error("memory forwarded outside windows"); // R4
  AST_NO_DN_LINK_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid |-> $past(link_up)) else $error("downstream issue with link down"); // R8
endmodule

// File: tb/sim_rp_cfg_router.sv
`timescale 1ns/1ps
module sim_rp_cfg_router;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] rp_id = 16'h0310;
  logic        link_up = 1'b1;
  logic        req_valid = 1'b0, req_ready;
  logic [1:0]  req_kind = '0;
  logic        req_write = 1'b0;
  logic [7:0]  req_bus = '0;
  logic [4:0]  req_dev = '0;
  logic [2:0]  req_fn = '0;
  logic [5:0]  req_reg = '0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic        dn_valid, dn_write;
  logic [1:0]  dn_kind;
  logic [7:0]  dn_bus;
  logic [4:0]  dn_dev;
  logic [2:0]  dn_fn;
  logic [5:0]  dn_reg;
  logic [31:0] dn_addr, dn_wdata;
  logic [15:0] dn_rid, cpl_id;
  logic        dn_cpl_valid = 1'b0, dn_cpl_ur = 1'b0;
  logic [31:0] dn_cpl_data = '0;
  logic        cpl_valid, cpl_ur, cpl_has_data;
  logic [31:0] cpl_data;

  int total = 0, bad = 0;
  bit done = 0;
  localparam logic [7:0] SEC = 8'd4, SUB = 8'd7;
  logic [11:0] npb = 12'h100, npl = 12'h10F, pfb, pfl;

  always #2.5 clk = ~clk;

  rp_cfg_router u0 (.*);

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(logic [1:0] k, logic wr, logic [7:0] b, logic [4:0] d,
                       logic [5:0] r, logic [31:0] a, logic [31:0] wd);
    @(negedge clk);
    req_kind = k; req_write = wr; req_bus = b; req_dev = d; req_fn = 3'd2;
    req_reg = r; req_addr = a; req_wdata = wd; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic local_rd(logic [5:0] r, logic [7:0] b, logic [31:0] exp, string tag);
    issue(2'd0, 1'b0, b, 5'd9, r, 32'h0, 32'h0);
    chk(cpl_valid && !cpl_ur && cpl_has_data && !dn_valid, tag, {cpl_valid, cpl_ur, cpl_has_data, dn_valid}, 4'b1010);
    chk(cpl_data == exp, tag, cpl_data, exp);
  endtask

  task automatic local_wr(logic [5:0] r, logic [31:0] d);
    issue(2'd0, 1'b1, 8'd0, 5'd0, r, 32'h0, d);
    chk(cpl_valid && !cpl_has_data && !cpl_ur && cpl_data == 0, "R10 local write cpl", {cpl_valid, cpl_has_data, cpl_ur}, 3'b100);
  endtask

  task automatic fail_chk(logic wr, string tag);
    chk(!dn_valid, tag, dn_valid, 0);
    chk(cpl_valid && cpl_ur, tag, {cpl_valid, cpl_ur}, 2'b11);
    chk(cpl_has_data == !wr, {tag, " R10"}, cpl_has_data, !wr);
    chk(cpl_data == (wr ? 32'h0 : 32'hFFFF_FFFF), tag, cpl_data, wr ? 32'h0 : 32'hFFFF_FFFF);
  endtask

  task automatic cfg1_case(logic [7:0] b, logic [4:0] d, logic wr, logic lk);
    bit conv, fwd, send, ur;
    logic [31:0] rd;
    conv = (b == SEC) && (d == 0);
    fwd  = (b != SEC) && (b > SEC) && (b <= SUB);
    send = lk && (conv || fwd);
    ur   = (b == 8'd6);
    rd   = 32'hA500_0000 | 32'(b);
    link_up = lk;
    issue(2'd1, wr, b, d, 6'd17, 32'h0, 32'h1234_0000 | 32'(b));
    if (send) begin
      chk(dn_valid && !cpl_valid, conv ? "R2 issue" : "R1 issue", {dn_valid, cpl_valid}, 2'b10);
      chk(dn_kind == (conv ? 2'd0 : 2'd1), conv ? "R2 kind" : "R1 kind", dn_kind, conv ? 0 : 1);
      chk(dn_bus == b && dn_dev == d && dn_fn == 3'd2 && dn_reg == 6'd17 && dn_write == wr,
          "R1 fields", {dn_bus, dn_dev, dn_fn, dn_reg}, {b, d, 3'd2, 6'd17});
      chk(dn_rid == rp_id, "R5 dn_rid", dn_rid, rp_id);
      chk(!req_ready, "R11 busy", req_ready, 0);
      @(negedge clk);
      chk(!req_ready && !cpl_valid, "R11 wait", {req_ready, cpl_valid}, 0);
      dn_cpl_valid = 1'b1; dn_cpl_ur = ur; dn_cpl_data = rd;
      @(negedge clk);
      dn_cpl_valid = 1'b0;
      chk(cpl_valid && req_ready && cpl_ur == ur, "R11 done", {cpl_valid, req_ready, cpl_ur}, {2'b11, ur});
      chk(cpl_data == (wr ? 32'h0 : (ur ? 32'hFFFF_FFFF : rd)), "R7 data", cpl_data,
          wr ? 32'h0 : (ur ? 32'hFFFF_FFFF : rd));
      chk(cpl_has_data == !wr && cpl_id == rp_id, "R5 cpl_id", cpl_id, rp_id);
    end else if (!lk) fail_chk(wr, "R8 link down");
    else if (b == SEC) fail_chk(wr, "R6 absent device");
    else fail_chk(wr, "R9 out of range");
    link_up = 1'b1;
  endtask

  task automatic mem_case(logic [11:0] pg, logic wr, logic lk);
    bit hit;
    logic [31:0] a;
    hit = (npb <= npl && pg >= npb && pg <= npl) || (pfb <= pfl && pg >= pfb && pg <= pfl);
    a = {pg, 20'h3A5C4};
    link_up = lk;
    issue(2'd2, wr, 8'd0, 5'd0, 6'd0, a, 32'hCAFE_0000);
    if (hit && lk) begin
      chk(dn_valid && dn_kind == 2'd2 && dn_addr == a && !cpl_valid, "R4 forward", dn_addr, a);
      chk(req_ready, "R4 no wait", req_ready, 1);
    end else fail_chk(wr, lk ? "R4 outside window" : "R8 memory link down");
    link_up = 1'b1;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    pfb = 12'hFFF; pfl = 12'h000;
    repeat (3) @(negedge clk);
    chk(!dn_valid && !cpl_valid && req_ready, "R3 reset outputs", {dn_valid, cpl_valid, req_ready}, 3'b001);
    rst_n = 1'b1;
    @(negedge clk);
    local_rd(6'd0, 8'd0, 32'h0, "R3 reset buses");
    local_rd(6'd1, 8'd0, 32'h0000_0FFF, "R3 reset window");
    local_rd(6'd3, 8'd200, {16'h0, rp_id}, "R5 id reg");
    chk(cpl_id == rp_id, "R5 cpl_id local", cpl_id, rp_id);
    local_wr(6'd0, {16'h0, SUB, SEC});
    local_wr(6'd1, {4'h0, npl, 4'h0, npb});
    local_wr(6'd2, 32'h07FF_0800);
    local_wr(6'd9, 32'hFFFF_FFFF);
    pfb = 12'h800; pfl = 12'h7FF;
    local_rd(6'd0, 8'd77, {16'h0, SUB, SEC}, "R3 bus readback");
    local_rd(6'd2, 8'd0, 32'h07FF_0800, "R3 window readback");
    local_rd(6'd9, 8'd0, 32'h0, "R3 unused index");
    link_up = 1'b0;
    local_rd(6'd1, 8'd3, {4'h0, npl, 4'h0, npb}, "R3 local with link down");
    link_up = 1'b1;
    for (int b = 0; b < 10; b++)
      for (int d = 0; d < 2; d++)
        for (int w = 0; w < 2; w++) cfg1_case(8'(b), 5'(d), w[0], 1'b1);
    cfg1_case(8'd255, 5'd0, 1'b0, 1'b1);
    for (int b = 3; b < 9; b++)
      for (int w = 0; w < 2; w++) cfg1_case(8'(b), 5'd0, w[0], 1'b0);
    issue(2'd3, 1'b0, SEC, 5'd0, 6'd0, 32'h0, 32'h0);
    fail_chk(1'b0, "R9 reserved kind");
    local_rd(6'd0, 8'd0, {16'h0, SUB, SEC}, "R10 failed writes left regs");
    begin
      logic [11:0] pgs [10] = '{12'h0FF, 12'h100, 12'h105, 12'h10F, 12'h110,
                                12'h7FF, 12'h800, 12'h803, 12'h804, 12'hFFF};
      for (int p = 0; p < 10; p++)
        for (int w = 0; w < 2; w++) mem_case(pgs[p], w[0], 1'b1);
      local_wr(6'd2, 32'h0803_0800);
      pfl = 12'h803;
      for (int p = 0; p < 10; p++)
        for (int w = 0; w < 2; w++) mem_case(pgs[p], w[0], 1'b1);
      mem_case(12'h101, 1'b0, 1'b0);
      mem_case(12'h801, 1'b1, 1'b0);
    end
    repeat (2) @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule